// File: doc/BRIEF.md
# SIMD Array Eight-Neighbour Serial Exchange

This block is a small grid of processing elements driven by a single central sequencer. Every element holds one exchange register, and every element executes the same command on the same shared clock. The main operation is a bit-serial register-to-register move. Each element sends its register out one bit at a time on its outbound serial bit. At the same time it receives the register of one chosen neighbour on its inbound serial bit. A single global direction code picks that neighbour from the eight around it. The grid wraps at its edges like a torus.

Two further single-cycle operations exist besides the exchange:
- A scalar broadcast writes one value into the register of every element. In its targeted form it writes only the element named by an index.
- An OR reduction folds the registers of all elements into one scalar result.

The exchange registers are visible on a flat output bus so that the surrounding datapath can use them.

Top module: `simd_mesh_xchg`

## Requirements
- R1: After a cycle with rst_n low (synchronous, active low), every exchange register is zero and busy_o, done_o, red_valid_o and red_result_o are zero.
- R2: When idle, a cycle with bcast_en_i=1 and bcast_all_i=1 (and start_i=0) writes bcast_data_i into every element's register at the next clock edge.
- R3: When idle, a cycle with bcast_en_i=1 and bcast_all_i=0 writes bcast_data_i only into element bcast_idx_i, where element index = row*8 + column and row 0 is the north row. All other registers are unchanged.
- R4: Direction codes name the neighbour that every element receives from: 0=N (row-1), 1=NE (row-1, col+1), 2=E (col+1), 3=SE (row+1, col+1), 4=S (row+1), 5=SW (row+1, col-1), 6=W (col-1), 7=NW (row-1, col-1). When a transfer is done, each register holds the value that its source neighbour had when the transfer started.
- R5: Neighbour indices wrap modulo 4 rows and modulo 8 columns, so edge and corner elements exchange with the opposite edges.
- R6: The transfer is least significant bit first, one bit per cycle. After k shift cycles, a register holds {source[k-1:0], own[31:k]}.
- R7: An accepted start_i makes busy_o high for exactly 32 cycles, starting at the next edge. done_o is high only during the last of these cycles.
- R8: dir_i is sampled in the cycle where start is accepted. Changes on dir_i during a transfer have no effect.
- R9: start_i while busy is ignored: the transfer neither restarts nor lengthens.
- R10: bcast_en_i and red_en_i while busy are ignored: registers keep shifting normally and red_valid_o stays low.
- R11: When idle, a cycle with red_en_i=1 (with start_i=0 and bcast_en_i=0) gives red_valid_o=1 for one cycle at the next edge. red_result_o then equals the bitwise OR of all registers and holds that value until the next accepted reduction.
- R12: When idle and several requests arrive in the same cycle, start wins over broadcast, and broadcast wins over reduction. The losing requests are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared array clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Request a neighbour transfer |
| dir_i | input | 3 | Global direction code for the transfer |
| bcast_en_i | input | 1 | Request a scalar broadcast |
| bcast_all_i | input | 1 | 1: write all elements, 0: write element bcast_idx_i only |
| bcast_idx_i | input | 5 | Target element index for the targeted write |
| bcast_data_i | input | 32 | Scalar broadcast value |
| red_en_i | input | 1 | Request an OR reduction |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | Last shift cycle of a transfer |
| red_valid_o | output | 1 | Reduction result updated on the previous edge |
| red_result_o | output | 32 | OR of all registers at the accepted reduction |
| pe_regs_o | output | 1024 | All registers; element e at bits [e*32 +: 32] |

## Verification
Broadcast writes and reduction results appear one edge after the request cycle. A transfer accepted at one edge keeps busy_o high for the next 32 cycles, with done_o in the 32nd cycle, and it leaves the moved values in place at the edge that ends that cycle. The bench keeps a behavioural model that steps at every rising edge. It compares all outputs at the following falling edge, so each result is sampled in the cycle it is due. Directed checks also count cycles from the start request. They compare the finished array against a rotated copy of a snapshot for all eight codes, including the four corners.

// File: rtl/simd_xchg_pkg.sv
// Shared constants and helpers for the SIMD serial exchange array.
// Assumes row 0 is the north row and column 0 is the west column.
package simd_xchg_pkg;

    localparam int NUM_DIRS = 8;
    localparam int DIR_BITS = 3;

    typedef enum logic [DIR_BITS-1:0] {
        DIR_N  = 3'd0,
        DIR_NE = 3'd1,
        DIR_E  = 3'd2,
        DIR_SE = 3'd3,
        DIR_S  = 3'd4,
        DIR_SW = 3'd5,
        DIR_W  = 3'd6,
        DIR_NW = 3'd7
    } dir_e;

    // Flat index of the element that element (r,c) receives from for code d.
    function automatic int src_index(input int r, input int c, input int d,
                                     input int rows, input int cols);
        int dr;
        int dc;
        dr = 0;
        dc = 0;
        case (d)
            0: begin dr = -1; dc =  0; end
            1: begin dr = -1; dc =  1; end
            2: begin dr =  0; dc =  1; end
            3: begin dr =  1; dc =  1; end
            4: begin dr =  1; dc =  0; end
            5: begin dr =  1; dc = -1; end
            6: begin dr =  0; dc = -1; end
            default: begin dr = -1; dc = -1; end
        endcase
        return ((r + dr + rows) % rows) * cols + ((c + dc + cols) % cols);
    endfunction

endpackage

// File: rtl/simd_xchg_ctrl.sv
// Central sequencer: decides which request is accepted, latches the
// direction, counts the serial shift cycles and flags the last one.
// Assumes requests are single-cycle-level inputs sampled on each edge.
module simd_xchg_ctrl #(
    parameter int W  = 32,
    parameter int DW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic [DW-1:0] dir_i,
    input  logic          bcast_en_i,
    input  logic          red_en_i,
    output logic          busy_o,
    output logic          done_o,
    output logic [DW-1:0] dir_o,
    output logic          bc_acc_o,
    output logic          red_acc_o
);
    localparam int CW = (W > 1) ? $clog2(W) : 1;
    localparam logic [CW-1:0] LAST = CW'(W - 1);

    logic          busy_q;
    logic [CW-1:0] cnt_q;
    logic [DW-1:0] dir_q;
    logic          start_acc;

    // Request arbitration: start beats broadcast beats reduction, idle only.
    always_comb begin
        start_acc = !busy_q && start_i;
        bc_acc_o  = !busy_q && !start_i && bcast_en_i;
        red_acc_o = !busy_q && !start_i && !bcast_en_i && red_en_i;
    end

    // Transfer state: busy flag, shift counter and latched direction.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
            dir_q  <= '0;
        end else if (start_acc) begin
            busy_q <= 1'b1;
            cnt_q  <= '0;
            dir_q  <= dir_i;
        end else if (busy_q) begin
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q == LAST) begin
                busy_q <= 1'b0;
            end
        end
    end

    // Output view of the sequencer state.
    always_comb begin
        busy_o = busy_q;
        done_o = busy_q && (cnt_q == LAST);
        dir_o  = dir_q;
    end

    AST_DIR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q && !done_o |=> $stable(dir_q)); // R8
    AST_DONE_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !busy_q); // R7
    AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q && !done_o && start_i |=> busy_q && (cnt_q == $past(cnt_q) + 1'b1)); // R9
    AST_IDLE_NO_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_q |-> !done_o); // R7

endmodule

// File: rtl/simd_xchg_pe.sv
// One processing element: an exchange register that either loads a
// broadcast scalar or shifts right by one bit, taking the new MSB from the
// neighbour picked by the global direction code. Its LSB is the outbound bit.
// Assumes load and shift are never requested in the same cycle.
module simd_xchg_pe #(
    parameter int W  = 32,
    parameter int ND = 8,
    parameter int DW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          shift_en_i,
    input  logic          load_en_i,
    input  logic [W-1:0]  load_val_i,
    input  logic [DW-1:0] dir_i,
    input  logic [ND-1:0] nbr_bits_i,
    output logic          out_bit_o,
    output logic [W-1:0]  value_o
);
    logic [W-1:0] reg_q;
    logic         in_bit;

    // Inbound serial port: select one of the neighbour outbound bits.
    always_comb in_bit = nbr_bits_i[dir_i];

    // Exchange register: load, shift LSB-first, or hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reg_q <= '0;
        end else if (load_en_i) begin
            reg_q <= load_val_i;
        end else if (shift_en_i) begin
            reg_q <= {in_bit, reg_q[W-1:1]};
        end
    end

    // Outbound serial port and parallel view.
    always_comb begin
        out_bit_o = reg_q[0];
        value_o   = reg_q;
    end

    AST_PE_NO_LOAD_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
        !(shift_en_i && load_en_i)); // R10
    AST_PE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        load_en_i |=> value_o == $past(load_val_i)); // R2
    AST_PE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !load_en_i && !shift_en_i |=> $stable(value_o)); // R10
    AST_PE_SHIFT_IN: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en_i |=> value_o[W-1] == $past(nbr_bits_i[dir_i])); // R6

endmodule

// File: rtl/simd_xchg_reduce.sv
// Global OR reduction: folds all element registers into one scalar and
// registers it with a one-cycle valid pulse. Holds the result otherwise.
module simd_xchg_reduce #(
    parameter int N = 32,
    parameter int W = 32
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           red_acc_i,
    input  logic [N*W-1:0] regs_i,
    output logic           red_valid_o,
    output logic [W-1:0]   red_result_o
);
    logic [W-1:0] or_all;

    // OR fold across all elements.
    always_comb begin
        or_all = '0;
        for (int e = 0; e < N; e++) begin
            or_all = or_all | regs_i[e*W +: W];
        end
    end

    // Result register and valid pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            red_valid_o  <= 1'b0;
            red_result_o <= '0;
        end else begin
            red_valid_o <= red_acc_i;
            if (red_acc_i) begin
                red_result_o <= or_all;
            end
        end
    end

    AST_RED_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        red_acc_i |=> red_valid_o); // R11
    AST_RED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !red_acc_i |=> !red_valid_o && $stable(red_result_o)); // R11

endmodule

// File: rtl/simd_mesh_xchg.sv
// Top of the SIMD exchange array: ROWS x COLS elements under one sequencer,
// wired as an eight-neighbour torus, plus broadcast and OR reduction.
// Assumes all elements share clk and the synchronous active-low reset.
module simd_mesh_xchg #(
    parameter int ROWS = 4,
    parameter int COLS = 8,
    parameter int W    = 32
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  start_i,
    input  logic [simd_xchg_pkg::DIR_BITS-1:0]    dir_i,
    input  logic                                  bcast_en_i,
    input  logic                                  bcast_all_i,
    input  logic [$clog2(ROWS*COLS)-1:0]          bcast_idx_i,
    input  logic [W-1:0]                          bcast_data_i,
    input  logic                                  red_en_i,
    output logic                                  busy_o,
    output logic                                  done_o,
    output logic                                  red_valid_o,
    output logic [W-1:0]                          red_result_o,
    output logic [ROWS*COLS*W-1:0]                pe_regs_o
);
    import simd_xchg_pkg::*;

    localparam int N  = ROWS * COLS;
    localparam int IW = $clog2(N);

    logic [DIR_BITS-1:0] dir_q;
    logic                bc_acc;
    logic                red_acc;
    logic                busy;
    logic [N-1:0]        out_bits;
    logic [N*W-1:0]      regs_flat;

    simd_xchg_ctrl #(.W(W), .DW(DIR_BITS)) ctrl_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start_i),
        .dir_i     (dir_i),
        .bcast_en_i(bcast_en_i),
        .red_en_i  (red_en_i),
        .busy_o    (busy),
        .done_o    (done_o),
        .dir_o     (dir_q),
        .bc_acc_o  (bc_acc),
        .red_acc_o (red_acc)
    );

    for (genvar r = 0; r < ROWS; r++) begin : g_row
        for (genvar c = 0; c < COLS; c++) begin : g_col
            localparam int E = r * COLS + c;
            logic [NUM_DIRS-1:0] nbr;
            logic                load_en;

            // Toroidal neighbour wiring, one source per direction code.
            for (genvar d = 0; d < NUM_DIRS; d++) begin : g_dir
                localparam int SRC = src_index(r, c, d, ROWS, COLS);
                assign nbr[d] = out_bits[SRC];
            end

            // Broadcast write enable: all elements or the addressed one.
            always_comb load_en = bc_acc && (bcast_all_i || (bcast_idx_i == IW'(E)));

            simd_xchg_pe #(.W(W), .ND(NUM_DIRS), .DW(DIR_BITS)) pe_i (
                .clk       (clk),
                .rst_n     (rst_n),
                .shift_en_i(busy),
                .load_en_i (load_en),
                .load_val_i(bcast_data_i),
                .dir_i     (dir_q),
                .nbr_bits_i(nbr),
                .out_bit_o (out_bits[E]),
                .value_o   (regs_flat[E*W +: W])
            );
        end
    end

    simd_xchg_reduce #(.N(N), .W(W)) red_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .red_acc_i   (red_acc),
        .regs_i      (regs_flat),
        .red_valid_o (red_valid_o),
        .red_result_o(red_result_o)
    );

    // Outputs of the array.
    always_comb begin
        busy_o    = busy;
        pe_regs_o = regs_flat;
    end

    AST_BUSY_BLOCKS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !bc_acc && !red_acc); // R10
    AST_START_PRIORITY: assert property (@(posedge clk) disable iff (!rst_n)
        !busy && start_i |=> busy && $stable(regs_flat)); // R12

endmodule

// File: tb/simd_mesh_xchg_tb_top.sv
// Self-checking bench: behavioural model stepped on each rising edge and
// compared on each falling edge, plus directed checks per requirement.
module simd_mesh_xchg_tb_top;
    localparam int ROWS = 4;
    localparam int COLS = 8;
    localparam int W    = 32;
    localparam int N    = ROWS * COLS;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start_i = 1'b0;
    logic [2:0]        dir_i = '0;
    logic              bcast_en_i = 1'b0;
    logic              bcast_all_i = 1'b0;
    logic [4:0]        bcast_idx_i = '0;
    logic [W-1:0]      bcast_data_i = '0;
    logic              red_en_i = 1'b0;
    logic              busy_o, done_o, red_valid_o;
    logic [W-1:0]      red_result_o;
    logic [N*W-1:0]    pe_regs_o;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit cmp_on = 1'b0;

    always #10 clk = ~clk;  // 50 MHz

    simd_mesh_xchg dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .dir_i(dir_i),
        .bcast_en_i(bcast_en_i), .bcast_all_i(bcast_all_i),
        .bcast_idx_i(bcast_idx_i), .bcast_data_i(bcast_data_i),
        .red_en_i(red_en_i), .busy_o(busy_o), .done_o(done_o),
        .red_valid_o(red_valid_o), .red_result_o(red_result_o),
        .pe_regs_o(pe_regs_o)
    );

    // ---- behavioural model ----
    logic [W-1:0] m_reg [N];
    bit           m_busy;
    int           m_cnt;
    int           m_dir;
    bit           m_rv;
    logic [W-1:0] m_rr;

    function automatic int src_of(int e, int d);
        int dr[8] = '{-1, -1, 0, 1, 1, 1, 0, -1};
        int dc[8] = '{0, 1, 1, 1, 0, -1, -1, -1};
        int r = e / COLS;
        int c = e % COLS;
        return ((r + dr[d] + ROWS) % ROWS) * COLS + ((c + dc[d] + COLS) % COLS);
    endfunction

    always @(posedge clk) begin
        logic [W-1:0] old [N];
        logic [W-1:0] acc;
        for (int e = 0; e < N; e++) old[e] = m_reg[e];
        if (!rst_n) begin
            for (int e = 0; e < N; e++) m_reg[e] = '0;
            m_busy = 0; m_cnt = 0; m_dir = 0; m_rv = 0; m_rr = '0;
        end else if (m_busy) begin
            for (int e = 0; e < N; e++)
                m_reg[e] = {old[src_of(e, m_dir)][0], old[e][W-1:1]};
            if (m_cnt == W - 1) m_busy = 0;
            m_cnt++;
            m_rv = 0;
        end else if (start_i) begin
            m_busy = 1; m_cnt = 0; m_dir = int'(dir_i); m_rv = 0;
        end else if (bcast_en_i) begin
            for (int e = 0; e < N; e++)
                if (bcast_all_i || bcast_idx_i == 5'(e)) m_reg[e] = bcast_data_i;
            m_rv = 0;
        end else if (red_en_i) begin
            acc = '0;
            for (int e = 0; e < N; e++) acc |= old[e];
            m_rv = 1; m_rr = acc;
        end else begin
            m_rv = 0;
        end
        cycles++;
    end

    // Per-cycle comparison against the model (R1, R2, R3, R4, R6, R7, R11).
    always @(negedge clk) begin
        if (cmp_on) begin
            bit bad;
            bad = 0;
            checks++;
            if (busy_o !== m_busy || done_o !== (m_busy && m_cnt == W - 1)) begin
                bad = 1;
                $display("FAIL R7 cycle %0d busy/done act %b%b exp %b%b", cycles,
                         busy_o, done_o, m_busy, (m_busy && m_cnt == W - 1));
            end
            if (red_valid_o !== m_rv || red_result_o !== m_rr) begin
                bad = 1;
                $display("FAIL R11 cycle %0d reduce act %b/%h exp %b/%h", cycles,
                         red_valid_o, red_result_o, m_rv, m_rr);
            end
            for (int e = 0; e < N; e++) begin
                if (pe_regs_o[e*W +: W] !== m_reg[e]) begin
                    bad = 1;
                    $display("FAIL R6 cycle %0d elem %0d act %h exp %h", cycles, e,
                             pe_regs_o[e*W +: W], m_reg[e]);
                end
            end
            if (bad) errors++;
        end
    end

    // ---- directed helpers ----
    task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act %h exp %h", tag, act, exp);
        end
    endtask

    task automatic idle_cycle();
        @(negedge clk);
        start_i = 0; bcast_en_i = 0; red_en_i = 0; bcast_all_i = 0;
    endtask

    task automatic write_all(input logic [W-1:0] v);
        @(negedge clk);
        bcast_en_i = 1; bcast_all_i = 1; bcast_data_i = v;
        idle_cycle();
    endtask

    task automatic write_one(input int e, input logic [W-1:0] v);
        @(negedge clk);
        bcast_en_i = 1; bcast_all_i = 0; bcast_idx_i = 5'(e); bcast_data_i = v;
        idle_cycle();
    endtask

    task automatic run_xfer(input int d);
        logic [W-1:0] snap [N];
        for (int e = 0; e < N; e++) snap[e] = pe_regs_o[e*W +: W];
        @(negedge clk);
        start_i = 1; dir_i = 3'(d);
        @(negedge clk);
        start_i = 0;
        for (int k = 0; k < W; k++) begin
            chk($sformatf("R7 busy dir %0d k %0d", d, k), 32'(busy_o), 32'd1);
            chk($sformatf("R7 done dir %0d k %0d", d, k), 32'(done_o), 32'(k == W - 1));
            if (k == 4) begin  // R6 partial after 4 shift cycles
                chk($sformatf("R6 partial dir %0d", d), pe_regs_o[0 +: W],
                    {snap[src_of(0, d)][3:0], snap[0][W-1:4]});
            end
            start_i = (k == 5);                      // R9
            dir_i = (k == 5) ? 3'(d + 3) : dir_i;    // R8
            bcast_en_i = (k == 10); bcast_all_i = 1; bcast_data_i = 32'hFFFF_FFFF; // R10
            red_en_i = (k == 15);                    // R10
            if (k == 16) chk($sformatf("R10 no red valid dir %0d", d), 32'(red_valid_o), 32'd0);
            @(negedge clk);
            start_i = 0; bcast_en_i = 0; red_en_i = 0;
        end
        chk($sformatf("R9 busy ends dir %0d", d), 32'(busy_o), 32'd0);
        for (int e = 0; e < N; e++)
            chk($sformatf("R4 dir %0d elem %0d", d, e), pe_regs_o[e*W +: W], snap[src_of(e, d)]);
        if (d == 7) chk("R5 NW corner 0<-31", pe_regs_o[0 +: W], snap[31]);
        if (d == 3) chk("R5 SE corner 31<-0", pe_regs_o[31*W +: W], snap[0]);
        if (d == 1) chk("R5 NE corner 7<-24", pe_regs_o[7*W +: W], snap[24]);
        if (d == 5) chk("R5 SW corner 24<-7", pe_regs_o[24*W +: W], snap[7]);
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (50000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired act %0d exp below 50000", cycles);
        finish_run();
    end

    initial begin
        logic [W-1:0] acc;
        repeat (3) @(negedge clk);
        rst_n = 1;
        cmp_on = 1;
        // R1 reset state
        chk("R1 busy", 32'(busy_o), 32'd0);
        chk("R1 red_valid", 32'(red_valid_o), 32'd0);
        chk("R1 reg 17", pe_regs_o[17*W +: W], 32'd0);
        chk("R1 red_result", red_result_o, 32'd0);
        // R2 broadcast to all
        write_all(32'hA5A5_0F0F);
        chk("R2 elem 0", pe_regs_o[0 +: W], 32'hA5A5_0F0F);
        chk("R2 elem 31", pe_regs_o[31*W +: W], 32'hA5A5_0F0F);
        // R3 targeted write leaves others alone
        write_one(9, 32'h1234_5678);
        chk("R3 target 9", pe_regs_o[9*W +: W], 32'h1234_5678);
        chk("R3 other 8", pe_regs_o[8*W +: W], 32'hA5A5_0F0F);
        chk("R3 other 10", pe_regs_o[10*W +: W], 32'hA5A5_0F0F);
        // R11 reduction with a single set bit
        write_all(32'h0);
        write_one(22, 32'h0004_0000);
        @(negedge clk); red_en_i = 1;
        idle_cycle();
        chk("R11 valid", 32'(red_valid_o), 32'd1);
        chk("R11 single bit", red_result_o, 32'h0004_0000);
        idle_cycle();
        chk("R11 pulse ends", 32'(red_valid_o), 32'd0);
        chk("R11 result held", red_result_o, 32'h0004_0000);
        // distinct per-element values
        for (int e = 0; e < N; e++)
            write_one(e, {8'(e), 8'(~e), 16'(e * 977 + 3)});
        acc = '0;
        for (int e = 0; e < N; e++) acc |= {8'(e), 8'(~e), 16'(e * 977 + 3)};
        @(negedge clk); red_en_i = 1;
        idle_cycle();
        chk("R11 OR of distinct", red_result_o, acc);
        // R4 R5 R6 R7 R8 R9 R10: every direction code
        for (int d = 0; d < 8; d++) run_xfer(d);
        // R12 start beats broadcast and reduction
        for (int e = 0; e < N; e++) acc = pe_regs_o[3*W +: W];
        @(negedge clk);
        start_i = 1; dir_i = 3'd2; bcast_en_i = 1; bcast_all_i = 1;
        bcast_data_i = 32'hDEAD_BEEF; red_en_i = 1;
        idle_cycle();
        chk("R12 start wins busy", 32'(busy_o), 32'd1);
        chk("R12 no reduce", 32'(red_valid_o), 32'd0);
        repeat (W) idle_cycle();
        chk("R12 transfer result", pe_regs_o[2*W +: W], acc);
        // R12 broadcast beats reduction
        @(negedge clk);
        bcast_en_i = 1; bcast_all_i = 1; bcast_data_i = 32'h0F0F_1111; red_en_i = 1;
        idle_cycle();
        chk("R12 bcast wins", pe_regs_o[5*W +: W], 32'h0F0F_1111);
        chk("R12 reduce dropped", 32'(red_valid_o), 32'd0);
        // R1 reset mid-transfer
        @(negedge clk); start_i = 1; dir_i = 3'd4;
        idle_cycle();
        repeat (3) @(negedge clk);
        rst_n = 0;
        @(negedge clk);
        rst_n = 1;
        chk("R1 reset clears busy", 32'(busy_o), 32'd0);
        chk("R1 reset clears reg", pe_regs_o[5*W +: W], 32'd0);
        repeat (2) idle_cycle();
        finish_run();
    end

endmodule